// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block is the read-after-write hazard controller for an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory and write-back. Every instruction passes through all five stages. Registers are read only in decode and written only in write-back, so only read-after-write hazards need handling. The block is purely combinational. Its clock and reset feed only the embedded checks.

On the decode side it takes the instruction word and a two-bit format class. From these it extracts the two source register numbers, picks the destination field that suits the format, and reports which operands are really read. These values are meant to be captured into the execute-stage pipeline register.

On the execute side it compares the held source numbers against the destinations waiting in the EX/MEM and MEM/WB registers, and drives one bypass select for each ALU operand. The second operand of a store uses the same path. When a load sits in execute and the instruction in decode reads its result, the block raises a stall that freezes the PC and the IF/ID register, and a bubble that clears the control bits entering ID/EX. After that single bubble, the loaded value arrives through the MEM/WB bypass. A write-back in the same cycle as a decode read is assumed to be resolved by the register file.

Top module: `hz_unit`

## Requirements
- R1: The first source number is taken from instruction bits 25..21 and the second from bits 20..16, in every format.
- R2: Format code 0 (register-register) writes the register in bits 15..11 and reads both sources. Code 1 (register-immediate or load) writes the register in bits 20..16 and reads only the first source. Code 2 (store or branch) reads both sources and writes nothing. Code 3 (jump) reads and writes nothing. When nothing is written, the destination output is 0 and the write flag is low.
- R3: Select encoding: 2'b00 means the register file value, 2'b01 the MEM/WB value, 2'b10 the EX/MEM value. An operand that is read and equals a written, nonzero EX/MEM destination selects 2'b10.
- R4: An operand that is read and equals a written, nonzero MEM/WB destination, with no EX/MEM match, selects 2'b01.
- R5: When both EX/MEM and MEM/WB match the same operand, the EX/MEM value (2'b10) wins.
- R6: Register 0 never produces a bypass and never causes a stall, even if a write to it is flagged.
- R7: An operand that the execute-stage instruction does not read always selects 2'b00.
- R8: The stall is high in the same cycle that a written, nonzero load destination in execute equals a source that the decode instruction reads.
- R9: The bubble output equals the stall output in every cycle.
- R10: There is no stall when the instruction in execute is not a load, when the load writes nothing, or when the matching field is not a source of the decode instruction (for example, the destination field of format 1).
- R11: The second operand of a store in execute is bypassed by the same rules as an ALU operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for embedded checks |
| rst | input | 1 | Synchronous active-high reset for checks |
| id_instr | input | 32 | Instruction word in decode |
| id_fmt | input | 2 | Format class of decode instruction |
| ex_src_a | input | 5 | First source number held in ID/EX |
| ex_src_b | input | 5 | Second source number held in ID/EX |
| ex_use_a | input | 1 | Execute instruction reads first source |
| ex_use_b | input | 1 | Execute instruction reads second source |
| ex_dest | input | 5 | Destination held in ID/EX |
| ex_wen | input | 1 | ID/EX instruction writes a register |
| ex_is_load | input | 1 | ID/EX instruction is a load |
| mem_dest | input | 5 | Destination held in EX/MEM |
| mem_wen | input | 1 | EX/MEM instruction writes a register |
| wb_dest | input | 5 | Destination held in MEM/WB |
| wb_wen | input | 1 | MEM/WB instruction writes a register |
| id_src_a | output | 5 | Decoded first source number |
| id_src_b | output | 5 | Decoded second source number |
| id_use_a | output | 1 | Decode instruction reads first source |
| id_use_b | output | 1 | Decode instruction reads second source |
| id_dest | output | 5 | Decoded destination number |
| id_wen | output | 1 | Decode instruction writes a register |
| fwd_a | output | 2 | Bypass select for first operand |
| fwd_b | output | 2 | Bypass select for second operand |
| stall_o | output | 1 | Freeze PC and IF/ID |
| bubble_o | output | 1 | Clear control entering ID/EX |

## Verification
The hardest case to reach is a load in execute whose destination equals bits 20..16 of a format-1 instruction in decode. Those bits are that instruction's own destination, not a source, so no stall may occur. A second hard case is a double match in which EX/MEM and MEM/WB both hold the same register as a source. Random stimulus reaches both often because all register numbers are drawn from a pool of four values that includes register 0. Directed vectors add each of these cases in isolation, along with a flagged write to register 0.

// File: rtl/hz_pkg.sv
package hz_pkg;
    parameter int REG_W   = 5;
    parameter int INSTR_W = 32;

    localparam int SRC_A_LSB = 21;
    localparam int SRC_B_LSB = 16;
    localparam int DST_R_LSB = 11;
    localparam int N_OPND    = 2;

    typedef enum logic [1:0] {
        FMT_RR  = 2'd0,
        FMT_IMM = 2'd1,
        FMT_SB  = 2'd2,
        FMT_JMP = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_e;

    typedef struct packed {
        logic [REG_W-1:0] num;
        logic             wen;
    } wr_port_t;

    typedef struct packed {
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic [REG_W-1:0] dest;
        logic             use_a;
        logic             use_b;
        logic             wen;
    } dec_info_t;

    function automatic logic hits(input logic [REG_W-1:0] src,
                                  input logic             rd,
                                  input wr_port_t         w);
        return rd && w.wen && (w.num != '0) && (w.num == src);
    endfunction
endpackage

// File: rtl/hz_dest_decode.sv
module hz_dest_decode
    import hz_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  fmt_e               fmt,
    output dec_info_t          info
);
    always_comb begin
        info       = '0;
        info.src_a = instr[SRC_A_LSB +: REG_W];
        info.src_b = instr[SRC_B_LSB +: REG_W];
        unique case (fmt)
            FMT_RR: begin
                info.dest  = instr[DST_R_LSB +: REG_W];
                info.wen   = 1'b1;
                info.use_a = 1'b1;
                info.use_b = 1'b1;
            end
            FMT_IMM: begin
                info.dest  = instr[SRC_B_LSB +: REG_W];
                info.wen   = 1'b1;
                info.use_a = 1'b1;
            end
            FMT_SB: begin
                info.use_a = 1'b1;
                info.use_b = 1'b1;
            end
            default: ;
        endcase
    end

    assert_wen_fmt_R2: assert property (@(posedge clk) disable iff (rst)
        info.wen |-> (fmt == FMT_RR || fmt == FMT_IMM));
    assert_nodest_R2: assert property (@(posedge clk) disable iff (rst)
        !info.wen |-> info.dest == '0);
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] src,
    input  logic             rd,
    input  wr_port_t         mem_w,
    input  wr_port_t         wb_w,
    output fwd_e             sel
);
    logic mem_hit, wb_hit;

    always_comb begin
        mem_hit = hits(src, rd, mem_w);
        wb_hit  = hits(src, rd, wb_w);
        if (mem_hit)     sel = FWD_MEM;
        else if (wb_hit) sel = FWD_WB;
        else             sel = FWD_RF;
    end

    assert_no_zero_fwd_R6: assert property (@(posedge clk) disable iff (rst)
        sel != FWD_RF |-> src != '0);
    assert_unused_rf_R7: assert property (@(posedge clk) disable iff (rst)
        !rd |-> sel == FWD_RF);
    assert_mem_prio_R5: assert property (@(posedge clk) disable iff (rst)
        sel == FWD_WB |-> !(mem_w.wen && mem_w.num == src));
    assert_mem_match_R3: assert property (@(posedge clk) disable iff (rst)
        sel == FWD_MEM |-> (mem_w.wen && mem_w.num == src));
endmodule

// File: rtl/hz_load_stall.sv
module hz_load_stall
    import hz_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  dec_info_t dec,
    input  wr_port_t  ex_w,
    input  logic      ex_is_load,
    output logic      stall
);
    logic hit_a, hit_b;

    always_comb begin
        hit_a = hits(dec.src_a, dec.use_a, ex_w);
        hit_b = hits(dec.src_b, dec.use_b, ex_w);
        stall = ex_is_load && (hit_a || hit_b);
    end

    assert_stall_load_R10: assert property (@(posedge clk) disable iff (rst)
        stall |-> (ex_is_load && ex_w.wen));
    assert_stall_nz_R6: assert property (@(posedge clk) disable iff (rst)
        stall |-> ex_w.num != '0);
    assert_stall_used_R10: assert property (@(posedge clk) disable iff (rst)
        stall |-> (dec.use_a || dec.use_b));
endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] id_instr,
    input  logic [1:0]         id_fmt,
    input  logic [REG_W-1:0]   ex_src_a,
    input  logic [REG_W-1:0]   ex_src_b,
    input  logic               ex_use_a,
    input  logic               ex_use_b,
    input  logic [REG_W-1:0]   ex_dest,
    input  logic               ex_wen,
    input  logic               ex_is_load,
    input  logic [REG_W-1:0]   mem_dest,
    input  logic               mem_wen,
    input  logic [REG_W-1:0]   wb_dest,
    input  logic               wb_wen,
    output logic [REG_W-1:0]   id_src_a,
    output logic [REG_W-1:0]   id_src_b,
    output logic               id_use_a,
    output logic               id_use_b,
    output logic [REG_W-1:0]   id_dest,
    output logic               id_wen,
    output logic [1:0]         fwd_a,
    output logic [1:0]         fwd_b,
    output logic               stall_o,
    output logic               bubble_o
);
    dec_info_t        dec;
    wr_port_t         ex_w, mem_w, wb_w;
    logic [REG_W-1:0] opnd_src [N_OPND];
    logic             opnd_rd  [N_OPND];
    fwd_e             opnd_sel [N_OPND];
    logic             stall;

    assign ex_w  = '{num: ex_dest,  wen: ex_wen};
    assign mem_w = '{num: mem_dest, wen: mem_wen};
    assign wb_w  = '{num: wb_dest,  wen: wb_wen};

    hz_dest_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .instr (id_instr),
        .fmt   (fmt_e'(id_fmt)),
        .info  (dec)
    );

    assign opnd_src[0] = ex_src_a;
    assign opnd_src[1] = ex_src_b;
    assign opnd_rd[0]  = ex_use_a;
    assign opnd_rd[1]  = ex_use_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hz_fwd_pick u_pick (
            .clk   (clk),
            .rst   (rst),
            .src   (opnd_src[g]),
            .rd    (opnd_rd[g]),
            .mem_w (mem_w),
            .wb_w  (wb_w),
            .sel   (opnd_sel[g])
        );
    end

    hz_load_stall u_stall (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .ex_w       (ex_w),
        .ex_is_load (ex_is_load),
        .stall      (stall)
    );

    assign id_src_a = dec.src_a;
    assign id_src_b = dec.src_b;
    assign id_use_a = dec.use_a;
    assign id_use_b = dec.use_b;
    assign id_dest  = dec.dest;
    assign id_wen   = dec.wen;
    assign fwd_a    = opnd_sel[0];
    assign fwd_b    = opnd_sel[1];
    assign stall_o  = stall;
    assign bubble_o = stall;

    assert_jmp_nostall_R10: assert property (@(posedge clk) disable iff (rst)
        (fmt_e'(id_fmt) == FMT_JMP) |-> !stall_o);
    assert_bubble_R9: assert property (@(posedge clk) disable iff (rst)
        bubble_o == stall_o);
    assert_imm_src_R1: assert property (@(posedge clk) disable iff (rst)
        (fmt_e'(id_fmt) == FMT_IMM) |-> id_dest == id_src_b);
endmodule

// File: tb/hz_unit_tb_top.sv
module hz_unit_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [31:0] id_instr;
    logic [1:0]  id_fmt;
    logic [4:0]  ex_src_a, ex_src_b, ex_dest, mem_dest, wb_dest;
    logic        ex_use_a, ex_use_b, ex_wen, ex_is_load, mem_wen, wb_wen;
    logic [4:0]  id_src_a, id_src_b, id_dest;
    logic        id_use_a, id_use_b, id_wen, stall_o, bubble_o;
    logic [1:0]  fwd_a, fwd_b;

    int n_chk = 0;
    int n_bad = 0;

    hz_unit dut_i (.*);

    function automatic logic [1:0] e_fwd(input logic [4:0] s, input logic u);
        if (u && s != 0 && mem_wen && mem_dest == s) return 2'b10;
        if (u && s != 0 && wb_wen && wb_dest == s)   return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [4:0] e_dest();
        case (id_fmt)
            2'd0: return id_instr[15:11];
            2'd1: return id_instr[20:16];
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic e_ua(); return id_fmt != 2'd3; endfunction
    function automatic logic e_ub(); return id_fmt == 2'd0 || id_fmt == 2'd2; endfunction

    function automatic logic e_stall();
        logic ha, hb;
        ha = e_ua() && id_instr[25:21] == ex_dest;
        hb = e_ub() && id_instr[20:16] == ex_dest;
        return ex_is_load && ex_wen && ex_dest != 0 && (ha || hb);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        check(id_src_a == id_instr[25:21], "R1 src_a", id_src_a, id_instr[25:21]);
        check(id_src_b == id_instr[20:16], "R1 src_b", id_src_b, id_instr[20:16]);
        check(id_dest == e_dest(), "R2 dest", id_dest, e_dest());
        check(id_wen == (id_fmt < 2'd2), "R2 wen", id_wen, id_fmt < 2'd2);
        check(id_use_a == e_ua() && id_use_b == e_ub(), "R2 use", {id_use_a, id_use_b}, {e_ua(), e_ub()});
        check(fwd_a == e_fwd(ex_src_a, ex_use_a), "R3/R4/R5 fwd_a", fwd_a, e_fwd(ex_src_a, ex_use_a));
        check(fwd_b == e_fwd(ex_src_b, ex_use_b), "R11 fwd_b", fwd_b, e_fwd(ex_src_b, ex_use_b));
        check(stall_o == e_stall(), "R8/R10 stall", stall_o, e_stall());
        check(bubble_o == stall_o, "R9 bubble", bubble_o, stall_o);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
        check_all();
    endtask

    task automatic clear();
        id_instr = '0; id_fmt = 2'd3;
        ex_src_a = 0; ex_src_b = 0; ex_dest = 0; mem_dest = 0; wb_dest = 0;
        ex_use_a = 0; ex_use_b = 0; ex_wen = 0; ex_is_load = 0; mem_wen = 0; wb_wen = 0;
    endtask

    function automatic logic [31:0] mk(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
        return {6'h0, a, b, d, 11'h0};
    endfunction

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear();
        repeat (3) @(posedge clk);
        #1;
        check(stall_o == 0 && fwd_a == 0 && fwd_b == 0, "R9 reset idle", stall_o, 0);
        @(negedge clk); rst = 1'b0;

        // R2: register-register dest from bits 15..11
        clear(); id_instr = mk(5'd1, 5'd2, 5'd9); id_fmt = 2'd0; step();
        check(id_dest == 5'd9, "R2 rr dest", id_dest, 9);
        // R10: load dest equals imm-format dest field -> no stall
        clear(); id_instr = mk(5'd1, 5'd7, 5'd0); id_fmt = 2'd1;
        ex_dest = 5'd7; ex_wen = 1; ex_is_load = 1; step();
        check(stall_o == 0, "R10 imm dest field", stall_o, 0);
        // R8: load-use on first source
        id_instr = mk(5'd7, 5'd3, 5'd0); step();
        check(stall_o == 1 && bubble_o == 1, "R8 load-use", stall_o, 1);
        // R10: non-load producer
        ex_is_load = 0; step();
        check(stall_o == 0, "R10 alu producer", stall_o, 0);
        // R6: load to r0
        clear(); id_instr = mk(5'd0, 5'd0, 5'd0); id_fmt = 2'd0;
        ex_dest = 0; ex_wen = 1; ex_is_load = 1; step();
        check(stall_o == 0, "R6 r0 no stall", stall_o, 0);
        // R5: both match
        clear(); ex_src_a = 5'd4; ex_use_a = 1; mem_dest = 4; mem_wen = 1; wb_dest = 4; wb_wen = 1; step();
        check(fwd_a == 2'b10, "R5 priority", fwd_a, 2);
        // R4: load value after bubble arrives via MEM/WB
        mem_wen = 0; step();
        check(fwd_a == 2'b01, "R4 wb fwd", fwd_a, 1);
        // R6: r0 forward
        clear(); ex_use_a = 1; mem_wen = 1; wb_wen = 1; step();
        check(fwd_a == 2'b00, "R6 r0 no fwd", fwd_a, 0);
        // R7: unused operand
        clear(); ex_src_b = 5'd5; mem_dest = 5; mem_wen = 1; step();
        check(fwd_b == 2'b00, "R7 unused", fwd_b, 0);
        // R11: store data operand
        ex_use_b = 1; step();
        check(fwd_b == 2'b10, "R11 store fwd", fwd_b, 2);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            id_instr = $urandom;
            id_instr[25:21] = 5'($urandom_range(0, 3));
            id_instr[20:16] = 5'($urandom_range(0, 3));
            id_instr[15:11] = 5'($urandom_range(0, 3));
            id_fmt     = 2'($urandom_range(0, 3));
            ex_src_a   = 5'($urandom_range(0, 3));
            ex_src_b   = 5'($urandom_range(0, 3));
            ex_dest    = 5'($urandom_range(0, 3));
            mem_dest   = 5'($urandom_range(0, 3));
            wb_dest    = 5'($urandom_range(0, 3));
            ex_use_a   = 1'($urandom);
            ex_use_b   = 1'($urandom);
            ex_wen     = 1'($urandom);
            ex_is_load = 1'($urandom);
            mem_wen    = 1'($urandom);
            wb_wen     = 1'($urandom);
            #1;
            check_all();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule